// File: doc/BRIEF.md
# Ternary Multiply-Accumulate Unit

This block multiplies two unsigned 5-trit ternary operands and adds the 10-trit product to a running sum. Each trit is carried on two wires. The accumulator is not cleared at the start of a sequence. When a pair is marked as the first of a sequence, a selector passes an external bias into the adder in place of the accumulator. Every later valid pair is added to the stored sum, so after N accepted pairs the output holds bias + Σ x·w, taken modulo 3^10.

The product is built from single-trit multiply cells. Their rows are summed by ripple-carry ternary adders, and a second ripple-carry adder performs the accumulation. A parameter selects one of two forms. The serial form multiplies and accumulates in the same cycle. The pipelined form registers the product before the adder, so one pair is multiplied while the previous product is accumulated, at the cost of one extra cycle of latency. A sticky flag records a carry out of the top trit.

Top module: `ternary_mac`

## Requirements
- R1: Trits are coded 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. Trit k of a vector sits at bits [2k+1:2k], with trit 0 the least significant. Operands x and w are 5 trits wide, and bias and result are 10 trits wide.
- R2: A synchronous active-high reset sets the result to all-zero trits and clears the wrap flag.
- R3: An accepted pair with first_i high loads the result with (bias + x·w) mod 3^10.
- R4: An accepted pair with first_i low loads the result with (previous result + x·w) mod 3^10.
- R5: While valid_i is low the result and the wrap flag hold their values, and first_i and the data inputs have no effect.
- R6: With PIPE = 0 the effect of a pair accepted at a clock edge is visible after that edge. With PIPE = 1 it is visible one edge later.
- R7: The wrap flag goes high when an accumulation carries out of the top trit. It stays high for later pairs of the same sequence. A pair with first_i high sets it from that pair's own carry.
- R8: Every trit of the result always carries one of the three legal codes.
- R9: Pairs may be accepted on every cycle back to back in both forms, with no lost or merged pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| first_i | input | 1 | Marks the first pair of a sequence (selects bias) |
| valid_i | input | 1 | Pair on x_i/w_i is accepted this cycle |
| x_i | input | 10 | Data operand, 5 trits |
| w_i | input | 10 | Weight operand, 5 trits |
| bias_i | input | 20 | Seed value for a sequence, 10 trits |
| acc_o | output | 20 | Accumulated result, 10 trits |
| wrap_o | output | 1 | Sticky carry-out-of-top-trit flag |

## Verification
The bench builds two copies of the unit with 5-trit operands, one with PIPE = 0 and one with PIPE = 1. Both copies see the same stimulus, so a single reference model checks both the serial timing and the one-cycle lag of the pipelined form, including back-to-back pairs and idle gaps. With 5 trits per operand the largest product, 242·242, combined with a near-full bias can carry out of the top trit, so wraparound and the sticky flag are reached with directed values.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
  typedef logic [1:0] trit_t;

  // True when no trit in the vector uses the spare code 2'b11.
  function automatic logic trits_legal(input logic [63:0] v, input int n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (v[2*k +: 2] == 2'b11) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/tern_fa.sv
module tern_fa
  import tmac_pkg::*;
(
  input  trit_t a,
  input  trit_t b,
  input  logic  ci,
  output trit_t s,
  output logic  co
);
  logic [2:0] tot;
  always_comb begin
    tot = {1'b0, a} + {1'b0, b} + {2'b00, ci};
    if (tot >= 3'd3) begin
      s  = trit_t'(tot - 3'd3);
      co = 1'b1;
    end else begin
      s  = trit_t'(tot);
      co = 1'b0;
    end
  end
endmodule

// File: rtl/tern_rca.sv
module tern_rca #(
  parameter int W = 10
) (
  input  logic [2*W-1:0] a,
  input  logic [2*W-1:0] b,
  input  logic           ci,
  output logic [2*W-1:0] s,
  output logic           co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_cell
    tern_fa u_fa (
      .a (a[2*i +: 2]),
      .b (b[2*i +: 2]),
      .ci(c[i]),
      .s (s[2*i +: 2]),
      .co(c[i+1])
    );
  end
  assign co = c[W];
endmodule

// File: rtl/tern_row.sv
module tern_row
  import tmac_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [2*N-1:0]   x,
  input  trit_t            d,
  output logic [2*N+1:0]   r
);
  logic [N:0] c;
  assign c[0] = 1'b0;
  for (genvar j = 0; j < N; j++) begin : g_dig
    logic [3:0] m;
    always_comb begin
      m = 4'(x[2*j +: 2]) * 4'(d) + 4'(c[j]);
      c[j+1] = (m >= 4'd3);
      r[2*j +: 2] = c[j+1] ? trit_t'(m - 4'd3) : trit_t'(m);
    end
  end
  assign r[2*N +: 2] = {1'b0, c[N]};
endmodule

// File: rtl/tern_mult.sv
module tern_mult #(
  parameter int N = 5,
  localparam int PW = 4*N
) (
  input  logic [2*N-1:0] x,
  input  logic [2*N-1:0] w,
  output logic [PW-1:0]  p,
  output logic           spill
);
  logic [PW-1:0] part [N];
  logic [N-1:0]  cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [2*N+1:0] row;
    logic [PW-1:0]  sh;
    tern_row #(.N(N)) u_row (.x(x), .d(w[2*i +: 2]), .r(row));
    assign sh = PW'(row) << (2*i);
    if (i == 0) begin : g_first
      assign part[0] = sh;
    end else begin : g_add
      tern_rca #(.W(2*N)) u_add (
        .a (part[i-1]),
        .b (sh),
        .ci(1'b0),
        .s (part[i]),
        .co(cy[i])
      );
    end
  end

  assign p     = part[N-1];
  assign spill = |cy;
endmodule

// File: rtl/ternary_mac.sv
module ternary_mac
  import tmac_pkg::*;
#(
  parameter int NT   = 5,
  parameter bit PIPE = 1'b0,
  localparam int AT  = 2*NT,
  localparam int XW  = 2*NT,
  localparam int AW  = 2*AT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          first_i,
  input  logic          valid_i,
  input  logic [XW-1:0] x_i,
  input  logic [XW-1:0] w_i,
  input  logic [AW-1:0] bias_i,
  output logic [AW-1:0] acc_o,
  output logic          wrap_o
);
  logic [AW-1:0] prod, prod_s, bias_s, addend, sum, acc_q;
  logic          spill, first_s, valid_s, co, wrap_q;

  tern_mult #(.N(NT)) u_mult (.x(x_i), .w(w_i), .p(prod), .spill(spill));

  if (PIPE) begin : g_pipe
    logic [AW-1:0] prod_q, bias_q;
    logic          first_q, valid_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q  <= '0;
        bias_q  <= '0;
        first_q <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        prod_q  <= prod;
        bias_q  <= bias_i;
        first_q <= first_i;
        valid_q <= valid_i;
      end
    end
    assign prod_s  = prod_q;
    assign bias_s  = bias_q;
    assign first_s = first_q;
    assign valid_s = valid_q;

    // R6: an accepted pair reaches the accumulate stage one cycle later
    assert_pipe_lag_R6: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_q);
  end else begin : g_serial
    assign prod_s  = prod;
    assign bias_s  = bias_i;
    assign first_s = first_i;
    assign valid_s = valid_i;
  end

  assign addend = first_s ? bias_s : acc_q;

  tern_rca #(.W(AT)) u_acc_add (
    .a (prod_s),
    .b (addend),
    .ci(1'b0),
    .s (sum),
    .co(co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else if (valid_s) begin
      acc_q  <= sum;
      wrap_q <= first_s ? co : (wrap_q | co);
    end
  end

  assign acc_o  = acc_q;
  assign wrap_o = wrap_q;

  // R2: reset leaves a zero result and a clear flag
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !wrap_q));

  // R5: no accepted pair, no change
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !valid_s |=> ($stable(acc_q) && $stable(wrap_q)));

  // R7: flag stays up across non-first pairs
  assert_wrap_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_s && !first_s && wrap_q) |=> wrap_q);

  // R8: result trits never use the spare code
  assert_legal_trits_R8: assert property (@(posedge clk) disable iff (rst)
    trits_legal(64'(acc_q), AT));

  // R3: the product of two legal operands fits in the product width
  assert_prod_fits_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && trits_legal(64'(x_i), NT) && trits_legal(64'(w_i), NT)) |-> !spill);
endmodule

// File: tb/sim_ternary_mac.sv
`timescale 1ns/1ps
module sim_ternary_mac;
  localparam int MOD = 59049;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        first_i = 1'b0, valid_i = 1'b0;
  logic [9:0]  x_i = '0, w_i = '0;
  logic [19:0] bias_i = '0;
  logic [19:0] acc0, acc1;
  logic        wrap0, wrap1;

  int n_chk = 0, n_bad = 0;
  int m_acc = 0, p_acc = 0;
  bit m_wrap = 0, p_wrap = 0;

  always #4 clk = ~clk;

  ternary_mac #(.NT(5), .PIPE(1'b0)) u0 (
    .clk(clk), .rst(rst), .first_i(first_i), .valid_i(valid_i),
    .x_i(x_i), .w_i(w_i), .bias_i(bias_i), .acc_o(acc0), .wrap_o(wrap0));

  ternary_mac #(.NT(5), .PIPE(1'b1)) u1 (
    .clk(clk), .rst(rst), .first_i(first_i), .valid_i(valid_i),
    .x_i(x_i), .w_i(w_i), .bias_i(bias_i), .acc_o(acc1), .wrap_o(wrap1));

  // R1: trit k at bits [2k+1:2k], codes 00/01/10
  function automatic logic [19:0] enc(input int v, input int n);
    logic [19:0] o;
    int t;
    o = '0;
    t = v;
    for (int k = 0; k < n; k++) begin
      o[2*k +: 2] = 2'(t % 3);
      t = t / 3;
    end
    return o;
  endfunction

  function automatic bit legal20(input logic [19:0] v);
    for (int k = 0; k < 10; k++) if (v[2*k +: 2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Called at a falling edge: drive, clock once, check at the next falling edge.
  task automatic step(input string tag, input bit st, input bit vl,
                      input int xv, input int wv, input int bv);
    int tot;
    first_i = st; valid_i = vl;
    x_i = enc(xv, 5)[9:0]; w_i = enc(wv, 5)[9:0]; bias_i = enc(bv, 10);
    p_acc = m_acc; p_wrap = m_wrap;
    if (vl) begin
      tot = (st ? bv : m_acc) + xv * wv;
      m_acc = tot % MOD;
      m_wrap = st ? (tot >= MOD) : (m_wrap | (tot >= MOD));
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " serial acc"}, acc0, enc(m_acc, 10));
    chk({tag, " serial wrap"}, {19'b0, wrap0}, {19'b0, m_wrap});
    chk({tag, " R6 pipelined acc"}, acc1, enc(p_acc, 10));
    chk({tag, " R6 pipelined wrap"}, {19'b0, wrap1}, {19'b0, p_wrap});
    chk("R8 legal codes", {19'b0, legal20(acc0) & legal20(acc1)}, 20'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R2 reset acc", acc0, '0);
    chk("R2 reset wrap", {19'b0, wrap0 | wrap1}, 20'd0);
    chk("R2 reset acc pipelined", acc1, '0);

    // R1/R3: small directed sequence, 1*2 + 4
    step("R1 R3", 1, 1, 1, 2, 4);
    step("R4", 0, 1, 2, 2, 0);
    step("R5 idle with first high", 1, 0, 242, 242, 100);
    step("R5 idle", 0, 0, 7, 9, 3);
    step("R4", 0, 1, 10, 11, 0);
    // R7: maximal operands and near-full bias overflow
    step("R7 wrap", 1, 1, 242, 242, MOD - 1);
    step("R7 sticky", 0, 1, 0, 5, 0);
    step("R7 sticky", 0, 1, 3, 3, 0);
    step("R7 cleared by first", 1, 1, 2, 2, 1);
    step("R3 zero product", 1, 1, 0, 242, 59000);

    // R9: random sequences, mostly back to back with occasional gaps
    for (int s = 0; s < 200; s++) begin
      int len;
      len = 1 + int'($urandom % 8);
      step("R3 rnd", 1, 1, int'($urandom % 243), int'($urandom % 243),
           int'($urandom % MOD));
      for (int k = 0; k < len; k++) begin
        if ($urandom % 4 == 0)
          step("R5 rnd", bit'($urandom % 2), 0, int'($urandom % 243),
               int'($urandom % 243), int'($urandom % MOD));
        step("R4 R9 rnd", 0, 1, int'($urandom % 243), int'($urandom % 243), 0);
      end
    end
    step("R6 drain", 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule